// File: doc/BRIEF.md
# Register Alias Writer Tracking Table

This block records, for every architectural register, which in-flight writer last defined it, so that a dispatch stage can find the producers a source operand must wait for. Registers may overlap: a wide register contains narrower sub-registers. The overlap relation is fixed at build time by a parameter matrix. An allocating write always claims the register and all of its sub-registers. It claims the enclosing super-registers only when it is marked as a full update. A retiring writer releases its claims. A claim is dropped only where the entry still names that writer, so a younger producer that has since taken over an entry keeps it.

A lookup port returns a bit vector indexed by writer tag. The vector covers the producer of the named register and the producers of each of its sub-registers, with repeated tags merged. The lookup is combinational and reflects only allocations from earlier cycles. A counter tracks the mappings in use. It is checked against a shared pool of temporaries when the dispatch stage asks whether N more writes would fit. Peak usage and lifetime allocation counters are also kept.

Top module: `rat_writer_table`

## Requirements
- R1: An allocate to register ID r with tag t sets the entry of r and of every sub-register of r (per SUB_MAP, where bit r*NUM_REGS+s set means s is a sub-register of r) to valid with tag t, from the next cycle on.
- R2: Super-registers of r are set to tag t only when alloc_full is 1; with alloc_full 0 their entries keep their previous contents.
- R3: A release of register r with tag t clears an entry of r or of its aliases only if that entry is valid and holds tag t; entries that hold another tag are left unchanged.
- R4: A release with rel_full 0 leaves super-register entries untouched even when they hold tag t.
- R5: lk_writers has bit k set exactly when tag k is held by a valid entry of lk_reg or of one of its sub-registers; a tag held by several such entries appears once.
- R6: used_cnt rises by one on each accepted allocate and falls by one on each release whose own register entry is valid (it never goes below zero); both in one cycle leave it unchanged.
- R7: peak_cnt holds the highest value used_cnt has reached and total_cnt counts accepted allocates since reset.
- R8: avail_ok is 1 when req_writes + used_cnt <= POOL_SIZE, and always 1 when POOL_SIZE is 0.
- R9: Allocate and release requests naming register ID 0 are ignored: no entry and no counter changes.
- R10: An allocate and a release in the same cycle act as if the release came first and the allocate second.
- R11: After reset all entries are invalid, lk_writers is 0 and all three counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Allocate request valid |
| alloc_reg | input | REG_W | Register ID being written |
| alloc_tag | input | TAG_W | Tag of the new writer |
| alloc_full | input | 1 | Write fully updates super-registers |
| rel_en | input | 1 | Release request valid |
| rel_reg | input | REG_W | Register ID of the retiring write |
| rel_tag | input | TAG_W | Tag of the retiring writer |
| rel_full | input | 1 | Retiring write was a full update |
| lk_reg | input | REG_W | Register ID read by a source operand |
| lk_writers | output | 2**TAG_W | Set of writer tags the read depends on |
| req_writes | input | REQ_W | Number of new writes asking for room |
| avail_ok | output | 1 | Requested writes fit in the pool |
| used_cnt | output | CNT_W | Mappings currently in use |
| peak_cnt | output | CNT_W | Highest value of used_cnt |
| total_cnt | output | CNT_W | Accepted allocates since reset |

## Verification
The hardest case to reach is a release that finds its own aliased entries already taken over by younger writers. It needs a chain of overlapping writes: a full write of a wide register, then a partial write of a narrow one, then a full write of a middle register. After this chain the older tags survive only in some entries. The stimulus builds that chain on a three-level alias group. It then retires the writers oldest first and reads the table through lookups after every step. A second group drives an allocate and a release on the same aliases in a single cycle to expose the ordering.

// File: rtl/rat_pkg.sv
package rat_pkg;
  // Per-entry update decision for one cycle.
  typedef enum logic [1:0] {
    ENT_KEEP = 2'd0,
    ENT_SET  = 2'd1,
    ENT_CLR  = 2'd2
  } ent_act_e;

  // Release is applied first, allocate on top of it.
  function automatic ent_act_e resolve_act(input logic set_hit, input logic clr_hit);
    if (set_hit)      return ENT_SET;
    else if (clr_hit) return ENT_CLR;
    else              return ENT_KEEP;
  endfunction
endpackage

// File: rtl/rat_alias_map.sv
module rat_alias_map #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 3,
  parameter logic [NUM_REGS*NUM_REGS-1:0] SUB_MAP = '0
) (
  input  logic [REG_W-1:0]    reg_id,
  output logic [NUM_REGS-1:0] self_mask,
  output logic [NUM_REGS-1:0] sub_mask,
  output logic [NUM_REGS-1:0] sup_mask
);
  always_comb begin
    self_mask = '0;
    sub_mask  = '0;
    sup_mask  = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (int'(reg_id) == r) begin
        self_mask[r] = 1'b1;
        for (int s = 0; s < NUM_REGS; s++) begin
          sub_mask[s] = SUB_MAP[r*NUM_REGS + s];
          sup_mask[s] = SUB_MAP[s*NUM_REGS + r];
        end
      end
    end
  end
endmodule

// File: rtl/rat_pool_ctr.sv
module rat_pool_ctr #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned REQ_W     = 4,
  parameter int unsigned POOL_SIZE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic [REQ_W-1:0] req_writes,
  output logic             avail_ok,
  output logic [CNT_W-1:0] used_q,
  output logic [CNT_W-1:0] peak_q,
  output logic [CNT_W-1:0] total_q
);
  localparam logic [CNT_W:0] POOL_LIM = (CNT_W+1)'(POOL_SIZE);

  logic [CNT_W-1:0] used_nx;
  logic [CNT_W:0]   demand;

  always_comb begin
    used_nx = used_q;
    if (inc && !dec)                      used_nx = used_q + 1'b1;
    else if (dec && !inc && used_q != '0) used_nx = used_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q  <= '0;
      peak_q  <= '0;
      total_q <= '0;
    end else begin
      used_q <= used_nx;
      if (used_nx > peak_q) peak_q <= used_nx;
      if (inc) total_q <= total_q + 1'b1;
    end
  end

  assign demand   = {1'b0, used_q} + (CNT_W+1)'(req_writes);
  assign avail_ok = (POOL_SIZE == 0) || (demand <= POOL_LIM);

  // R6
  used_step_chk: assert property (@(posedge clk) disable iff (rst)
    (used_q == $past(used_q)) || (used_q == $past(used_q) + 1'b1) ||
    (used_q == $past(used_q) - 1'b1));
  // R7
  peak_cover_chk: assert property (@(posedge clk) disable iff (rst)
    peak_q >= used_q);
  // R7
  total_step_chk: assert property (@(posedge clk) disable iff (rst)
    (total_q == $past(total_q)) || (total_q == $past(total_q) + 1'b1));
endmodule

// File: rtl/rat_writer_table.sv
module rat_writer_table
  import rat_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned TAG_W     = 3,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned REQ_W     = 4,
  parameter int unsigned POOL_SIZE = 4,
  parameter logic [NUM_REGS*NUM_REGS-1:0] SUB_MAP = 64'h0000_0020_0008_0C00,
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned NUM_TAGS = 2**TAG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alloc_en,
  input  logic [REG_W-1:0]    alloc_reg,
  input  logic [TAG_W-1:0]    alloc_tag,
  input  logic                alloc_full,
  input  logic                rel_en,
  input  logic [REG_W-1:0]    rel_reg,
  input  logic [TAG_W-1:0]    rel_tag,
  input  logic                rel_full,
  input  logic [REG_W-1:0]    lk_reg,
  output logic [NUM_TAGS-1:0] lk_writers,
  input  logic [REQ_W-1:0]    req_writes,
  output logic                avail_ok,
  output logic [CNT_W-1:0]    used_cnt,
  output logic [CNT_W-1:0]    peak_cnt,
  output logic [CNT_W-1:0]    total_cnt
);
  logic [NUM_REGS-1:0] ent_v;
  logic [TAG_W-1:0]    ent_tag [NUM_REGS];

  logic [NUM_REGS-1:0] a_self, a_sub, a_sup;
  logic [NUM_REGS-1:0] r_self, r_sub, r_sup;
  logic [NUM_REGS-1:0] l_self, l_sub, l_sup;

  logic alloc_go, rel_go, rel_live;

  assign alloc_go = alloc_en && (alloc_reg != '0);
  assign rel_go   = rel_en && (rel_reg != '0);
  assign rel_live = rel_go && ent_v[rel_reg];

  rat_alias_map #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .SUB_MAP(SUB_MAP)) alloc_map_i (
    .reg_id(alloc_reg), .self_mask(a_self), .sub_mask(a_sub), .sup_mask(a_sup));
  rat_alias_map #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .SUB_MAP(SUB_MAP)) rel_map_i (
    .reg_id(rel_reg), .self_mask(r_self), .sub_mask(r_sub), .sup_mask(r_sup));
  rat_alias_map #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .SUB_MAP(SUB_MAP)) lk_map_i (
    .reg_id(lk_reg), .self_mask(l_self), .sub_mask(l_sub), .sup_mask(l_sup));

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_ent
      logic     set_hit, clr_hit;
      ent_act_e act;
      always_comb begin
        set_hit = alloc_go && (a_self[g] || a_sub[g] || (alloc_full && a_sup[g]));
        clr_hit = rel_go && (r_self[g] || r_sub[g] || (rel_full && r_sup[g])) &&
                  ent_v[g] && (ent_tag[g] == rel_tag);
        act     = resolve_act(set_hit, clr_hit);
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          ent_v[g]   <= 1'b0;
          ent_tag[g] <= '0;
        end else begin
          case (act)
            ENT_SET: begin
              ent_v[g]   <= 1'b1;
              ent_tag[g] <= alloc_tag;
            end
            ENT_CLR: ent_v[g] <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  endgenerate

  always_comb begin
    lk_writers = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (ent_v[r] && (l_self[r] || l_sub[r]))
        lk_writers[ent_tag[r]] = 1'b1;
  end

  rat_pool_ctr #(.CNT_W(CNT_W), .REQ_W(REQ_W), .POOL_SIZE(POOL_SIZE)) pool_i (
    .clk(clk), .rst(rst), .inc(alloc_go), .dec(rel_live),
    .req_writes(req_writes), .avail_ok(avail_ok),
    .used_q(used_cnt), .peak_q(peak_cnt), .total_q(total_cnt));

  // R1
  alloc_own_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_go |=> ent_v[$past(alloc_reg)] && (ent_tag[$past(alloc_reg)] == $past(alloc_tag)));
  // R3
  foreign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_go && !alloc_en && ent_v[rel_reg] && (ent_tag[rel_reg] != rel_tag))
      |=> ent_v[$past(rel_reg)] && (ent_tag[$past(rel_reg)] == $past(ent_tag[rel_reg])));
  // R9
  zero_id_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && alloc_reg == '0 && !rel_en) |=> $stable(ent_v));
  // R5
  lk_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(lk_writers) <= $countones(ent_v)));
endmodule

// File: tb/rat_writer_table_tb.sv
`timescale 1ns/1ps
module rat_writer_table_tb_top;
  localparam int unsigned NR = 8, TW = 3, CW = 8, RW = 4, RGW = 3, NT = 8;

  typedef enum int {K_LK, K_USED, K_PEAK, K_TOTAL, K_AVAIL, K_UNL} kind_e;
  typedef struct {
    kind_e       kind;
    int          arg;
    int          expv;
    string       req;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_en = 0, alloc_full = 0, rel_en = 0, rel_full = 0;
  logic [RGW-1:0] alloc_reg = '0, rel_reg = '0, lk_reg = '0;
  logic [TW-1:0]  alloc_tag = '0, rel_tag = '0;
  logic [RW-1:0]  req_writes = '0;
  logic [NT-1:0]  lk_writers, u_lk;
  logic           avail_ok, u_avail;
  logic [CW-1:0]  used_cnt, peak_cnt, total_cnt, u_used, u_peak, u_total;

  item_t q[$];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rat_writer_table dut_i (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .alloc_reg(alloc_reg), .alloc_tag(alloc_tag),
    .alloc_full(alloc_full), .rel_en(rel_en), .rel_reg(rel_reg), .rel_tag(rel_tag),
    .rel_full(rel_full), .lk_reg(lk_reg), .lk_writers(lk_writers), .req_writes(req_writes),
    .avail_ok(avail_ok), .used_cnt(used_cnt), .peak_cnt(peak_cnt), .total_cnt(total_cnt));

  rat_writer_table #(.POOL_SIZE(0)) dut_unl (
    .clk(clk), .rst(rst), .alloc_en(1'b0), .alloc_reg('0), .alloc_tag('0),
    .alloc_full(1'b0), .rel_en(1'b0), .rel_reg('0), .rel_tag('0),
    .rel_full(1'b0), .lk_reg(lk_reg), .lk_writers(u_lk), .req_writes(req_writes),
    .avail_ok(u_avail), .used_cnt(u_used), .peak_cnt(u_peak), .total_cnt(u_total));

  task automatic expect_it(kind_e k, int a, int e, string r);
    item_t it;
    it.kind = k; it.arg = a; it.expv = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    #1;
  endtask

  // Drives one cycle of requests, then releases the enables after the edge.
  task automatic step(bit ae, int ar, int at, bit af, bit re, int rr, int rt, bit rf);
    @(negedge clk);
    alloc_en = ae; alloc_reg = RGW'(ar); alloc_tag = TW'(at); alloc_full = af;
    rel_en = re; rel_reg = RGW'(rr); rel_tag = TW'(rt); rel_full = rf;
    @(posedge clk);
    #1;
    alloc_en = 0; rel_en = 0;
  endtask

  // Monitor: pops expected items and compares away from the clock edge.
  initial begin
    forever begin
      int act;
      item_t it;
      wait (q.size() > 0);
      it = q.pop_front();
      if (it.kind == K_LK) lk_reg = RGW'(it.arg);
      if (it.kind == K_AVAIL || it.kind == K_UNL) req_writes = RW'(it.arg);
      #1;
      case (it.kind)
        K_LK:    act = int'(lk_writers);
        K_USED:  act = int'(used_cnt);
        K_PEAK:  act = int'(peak_cnt);
        K_TOTAL: act = int'(total_cnt);
        K_AVAIL: act = int'(avail_ok);
        default: act = int'(u_avail);
      endcase
      n_chk++;
      if (act != it.expv) begin
        n_err++;
        $display("FAIL %s kind=%0d arg=%0d actual=0x%0h expected=0x%0h",
                 it.req, it.kind, it.arg, act, it.expv);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R11 reset state
    for (int r = 0; r < NR; r++) expect_it(K_LK, r, 0, "R11");
    expect_it(K_USED, 0, 0, "R11");
    expect_it(K_PEAK, 0, 0, "R11");
    expect_it(K_TOTAL, 0, 0, "R11");
    drain();

    // R1: full write of reg1 (subs 2,3) with tag 1
    step(1, 1, 1, 1, 0, 0, 0, 0);
    expect_it(K_LK, 3, 'h02, "R1");
    expect_it(K_LK, 1, 'h02, "R1");
    expect_it(K_USED, 0, 1, "R6");
    drain();

    // R2: partial write of reg3 tag 2 leaves supers 1,2 at tag 1
    step(1, 3, 2, 0, 0, 0, 0, 0);
    expect_it(K_LK, 1, 'h06, "R2");
    expect_it(K_LK, 2, 'h06, "R5");
    expect_it(K_LK, 3, 'h04, "R2");
    drain();

    // R2: full write of reg2 tag 3 also claims super reg1
    step(1, 2, 3, 1, 0, 0, 0, 0);
    expect_it(K_LK, 1, 'h08, "R2");
    expect_it(K_LK, 3, 'h08, "R1");
    expect_it(K_USED, 0, 3, "R6");
    expect_it(K_AVAIL, 1, 1, "R8");
    expect_it(K_AVAIL, 2, 0, "R8");
    expect_it(K_UNL, 15, 1, "R8");
    drain();

    // R3: release tag 1 full; all entries now owned by tag 3
    step(0, 0, 0, 0, 1, 1, 1, 1);
    expect_it(K_LK, 1, 'h08, "R3");
    expect_it(K_USED, 0, 2, "R6");
    // R3: release tag 2 partial on reg3 owned by tag 3
    step(0, 0, 0, 0, 1, 3, 2, 0);
    expect_it(K_LK, 3, 'h08, "R3");
    drain();

    // R4: partial release of reg2 tag 3 keeps super reg1
    step(0, 0, 0, 0, 1, 2, 3, 0);
    expect_it(K_LK, 2, 0, "R4");
    expect_it(K_LK, 1, 'h08, "R4");
    expect_it(K_USED, 0, 0, "R6");
    drain();

    // R10: reg4 full tag4, then same cycle release reg4 tag4 and alloc reg5 tag5
    step(1, 4, 4, 1, 0, 0, 0, 0);
    expect_it(K_LK, 4, 'h10, "R1");
    drain();
    step(1, 5, 5, 0, 1, 4, 4, 1);
    expect_it(K_LK, 4, 'h20, "R10");
    expect_it(K_LK, 5, 'h20, "R10");
    expect_it(K_USED, 0, 1, "R6");
    drain();

    // R9: register ID 0 is ignored
    step(1, 0, 6, 1, 0, 0, 0, 0);
    expect_it(K_LK, 0, 0, "R9");
    expect_it(K_USED, 0, 1, "R9");
    expect_it(K_TOTAL, 0, 5, "R9");
    step(0, 0, 0, 0, 1, 0, 5, 1);
    expect_it(K_USED, 0, 1, "R9");
    expect_it(K_LK, 5, 'h20, "R9");
    // R7 peak and total
    expect_it(K_PEAK, 0, 3, "R7");
    expect_it(K_TOTAL, 0, 5, "R7");
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule